// File: doc/BRIEF.md
# Odd-Forced Shift-Add Pseudorandom Candidate Generator

This block turns a seed into a stream of pseudorandom numbers meant as starting candidates for a prime search. A seed-load strobe captures a double-width seed. It splits the seed into two state words and conditions each one with a nonlinear term: the word is squared, the square is rotated, and the result is added back to the word. One conditioned word becomes the running mix word. The other becomes a fixed addend that stays the same until the next seed load.

A request strobe starts a run of 64 shift-add rounds on the mix word, one round per clock. At the end of the run a valid flag pulses for one cycle. At that point the result port shows the lower half of the mixed word, with its least significant bit and its top eight bits forced to one. Every candidate is therefore a large odd number. Each later request carries on from the mix word the previous run left behind. A new seed is used only when the seed-load strobe fires again.

Top module: `oddgen_prng`

## Requirements
- R1: While reset is asserted and after it is released, `valid` is 0 and `rnd` is 0.
- R2: A seed load takes A = `seed[W-1:0]` and C = `seed[2W-1:W]`. It sets the mix word B to A + rotl(A·A, 5) and the addend D to C + rotl(C·C, 13). Here rotl is a left rotation within W bits, and all arithmetic wraps modulo 2^W.
- R3: A request taken while idle at clock edge E runs one round per edge at edges E+1 through E+64. Each round computes B ← (B>>1) + (B<<1) + B + D modulo 2^W. `valid` is 1 for exactly the one cycle that follows edge E+64.
- R4: When `valid` is 1, `rnd` equals bits W/2-1..0 of the final B, with bit 0 forced to 1 and bits W/2-1..W/2-8 forced to 1.
- R5: A later request continues from the B left by the previous run. D is unchanged and no reseeding happens.
- R6: A request made while a run is in progress is ignored. It neither restarts nor lengthens the run, and it does not queue a second result.
- R7: A seed load has priority over everything else. It aborts any run in progress, and the aborted run never produces a `valid`. A request in the same cycle as a seed load is ignored.
- R8: `rnd` changes only in a cycle where `valid` is 1, and holds its value in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seed_load | input | 1 | Strobe: condition and load the seed |
| seed | input | 2*W | Seed; low half gives the mix word, high half gives the addend |
| req | input | 1 | Strobe: start a 64-round run |
| valid | output | 1 | One-cycle pulse when `rnd` holds a new candidate |
| rnd | output | W/2 | Odd candidate with its top byte set |

## Verification
The generator is driven with a sweep of seeds. The sweep includes all-zero and all-one seeds, where the squaring terms fold in very different ways, and seeds that differ in only one half. Several requests follow each seed, so both the one-time conditioning and the continuation of the mix word are tested against a bench model. Extra requests during a run show whether a busy request is dropped or restarts the run. A seed load in the middle of a run, with a simultaneous request, shows whether the aborted run leaks a result and whether the fresh state really replaces the old one.

// File: rtl/oddgen_prng.sv
module oddgen_prng #(
  parameter int W       = 32,
  parameter int ROUNDS  = 64,
  parameter int TOPBITS = 8,
  parameter int ROT_A   = 5,
  parameter int ROT_C   = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_load,
  input  logic [2*W-1:0]   seed,
  input  logic             req,
  output logic             valid,
  output logic [W/2-1:0]   rnd
);
  localparam int HW   = W / 2;
  localparam int CW   = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
  localparam logic [CW-1:0] LAST = CW'(ROUNDS - 1);

  logic [W-1:0]  mix_w, add_w;
  logic [CW-1:0] cnt;
  logic          busy;

  logic [W-1:0] sa, sc, sq_a, sq_c, cond_a, cond_c, nxt_b;
  logic [HW-1:0] mapped;

  assign sa   = seed[W-1:0];
  assign sc   = seed[2*W-1:W];
  assign sq_a = sa * sa;
  assign sq_c = sc * sc;
  assign cond_a = sa + ((sq_a << ROT_A) | (sq_a >> (W - ROT_A)));
  assign cond_c = sc + ((sq_c << ROT_C) | (sq_c >> (W - ROT_C)));

  assign nxt_b  = (mix_w >> 1) + (mix_w << 1) + mix_w + add_w;
  assign mapped = {{TOPBITS{1'b1}}, nxt_b[HW-TOPBITS-1:1], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mix_w <= '0;
      add_w <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      valid <= 1'b0;
      rnd   <= '0;
    end else if (seed_load) begin
      mix_w <= cond_a;
      add_w <= cond_c;
      cnt   <= '0;
      busy  <= 1'b0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (busy) begin
        mix_w <= nxt_b;
        if (cnt == LAST) begin
          busy  <= 1'b0;
          cnt   <= '0;
          valid <= 1'b1;
          rnd   <= mapped;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (req) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end
  end

  AST_VALID_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> rnd[0]);                                        // R4
  AST_VALID_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (&rnd[HW-1 -: TOPBITS]));                       // R4
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);                                        // R3
  AST_SEED_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> (!valid && !busy));                         // R7
  AST_RUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seed_load && cnt != LAST) |=> (busy && !valid)); // R6
  AST_RND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> $stable(rnd));                                 // R8
endmodule

// File: tb/oddgen_prng_bench.sv
`timescale 1ns/1ps
module oddgen_prng_bench;
  localparam int W  = 32;
  localparam int HW = W / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seed_load = 1'b0;
  logic [2*W-1:0] seed = '0;
  logic req = 1'b0;
  logic valid;
  logic [HW-1:0] rnd;

  int tests = 0;
  int fails = 0;
  logic [W-1:0] mb, md;

  always #2 clk = ~clk;

  oddgen_prng u_oddgen_prng (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed(seed),
    .req(req), .valid(valid), .rnd(rnd)
  );

  function automatic logic [W-1:0] rotl(input logic [W-1:0] x, input int k);
    return (x << k) | (x >> (W - k));
  endfunction

  function automatic logic [W-1:0] cond(input logic [W-1:0] x, input int k);
    logic [W-1:0] s;
    s = x * x;
    return x + rotl(s, k);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_seed(input logic [2*W-1:0] s);
    mb = cond(s[W-1:0], 5);
    md = cond(s[2*W-1:W], 13);
  endtask

  function automatic logic [HW-1:0] model_run();
    for (int i = 0; i < 64; i++) mb = (mb >> 1) + (mb << 1) + mb + md;
    return {8'hFF, mb[HW-9:1], 1'b1};
  endfunction

  task automatic do_seed(input logic [2*W-1:0] s, input logic with_req);
    @(negedge clk);
    seed = s; seed_load = 1'b1; req = with_req;
    @(negedge clk);
    seed_load = 1'b0; req = 1'b0;
    model_seed(s);
  endtask

  // request; optional extra request at round index busy_at (0 = none)
  task automatic do_req(input int busy_at, input string tag);
    logic [HW-1:0] exp;
    int early;
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    early = 0;
    for (int i = 1; i <= 64; i++) begin
      if (busy_at != 0 && i == busy_at) req = 1'b1;
      if (busy_at != 0 && i == busy_at + 1) req = 1'b0;
      @(negedge clk);
      if (i < 64 && valid) early++;
    end
    exp = model_run();
    check({tag, " R3 early valid count"}, 64'(early), 64'd0);
    check({tag, " R3 valid at round 64"}, 64'(valid), 64'd1);
    check({tag, " R4 candidate"}, 64'(rnd), 64'(exp));
    @(negedge clk);
    check({tag, " R3 one-cycle valid"}, 64'(valid), 64'd0);
    check({tag, " R8 hold"}, 64'(rnd), 64'(exp));
  endtask

  task automatic quiet(input int n, input string tag);
    int seen;
    logic [HW-1:0] r0;
    seen = 0;
    r0 = rnd;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (valid) seen++;
    end
    check({tag, " no stray valid"}, 64'(seen), 64'd0);
    check({tag, " R8 rnd unchanged"}, 64'(rnd), 64'(r0));
  endtask

  initial begin
    #150000;
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [2*W-1:0] seeds [8];
    seeds[0] = 64'h0;
    seeds[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    seeds[2] = 64'h0000_0001_0000_0001;
    seeds[3] = 64'h1234_5678_9ABC_DEF0;
    seeds[4] = 64'hDEAD_BEEF_0000_0000;
    seeds[5] = 64'h0000_0000_CAFE_F00D;
    seeds[6] = 64'h8000_0000_8000_0000;
    seeds[7] = 64'h0F0F_1E1E_7070_A5A5;

    repeat (3) @(negedge clk);
    check("R1 valid in reset", 64'(valid), 64'd0);
    check("R1 rnd in reset", 64'(rnd), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", 64'(valid), 64'd0);
    check("R1 rnd after reset", 64'(rnd), 64'd0);

    for (int s = 0; s < 8; s++) begin
      do_seed(seeds[s], 1'b0);
      do_req(0, "R2 first");
      do_req(0, "R5 second");
      do_req(0, "R5 third");
    end

    // R6: request during a run is dropped
    do_seed(seeds[3], 1'b0);
    do_req(10, "R6 busy req");
    quiet(80, "R6");
    do_req(0, "R6 R5 continue");
    do_req(63, "R6 late busy req");
    quiet(80, "R6 late");

    // R7: seed load aborts a run; simultaneous request ignored
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (20) @(negedge clk);
    do_seed(seeds[7], 1'b1);
    quiet(90, "R7 abort");
    do_req(0, "R7 fresh state");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule